// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a free-running timebase. It can sit idle, take a timestamp of an external event, or watch the counter for a programmed value. In capture mode it picks one of eight trigger lines and synchronizes it. When it sees the chosen edge, it stores the current main counter value and raises an event.

In compare mode it checks its stored value for equality with a comparison key. The key is either the full main counter or a packed word made of the low main counter bits and the precounter. A mask count removes that many of the most significant bits from the test. On the first cycle of a match, the channel raises an event and applies one of four actions to its output pin. A timebase typically instantiates three of these channels, numbered 0 to 2.

Top module: `cc_channel`

## Requirements
- R1: After reset the stored value is 0, the output pin is low, the event output is low and the channel mode is off.
- R2: Mode code 0 is off, 1 is capture, 2 is compare, and 3 behaves as off. In off mode no event is raised and the pin does not change on a match.
- R3: In capture mode the selected line `trig_in[cfg_sel]` passes through a two-flop synchronizer. A qualifying edge loads `cnt` into the stored value and pulses `evt_o` for one cycle, three clock edges after the line changes. Unselected lines have no effect.
- R4: The trigger mode codes are: 0 rising, 1 falling, 2 both edges, 3 level. In level mode every cycle the synchronized line is high counts as a capture.
- R5: With base 0 the key is `cnt`. With base 1 the key is `{cnt[16:0], precnt[14:0]}`.
- R6: A mask count m (0 to 31) excludes the m most significant bits of key and stored value from the equality test.
- R7: A compare match raises `evt_o` once, in the cycle after the first cycle of equality, and not again while equality persists.
- R8: The action codes are: 0 pulse, 1 toggle, 2 clear, 3 set. The pin takes the new level in the same cycle as the event.
- R9: In pulse action the pin goes high with the event. It returns low on the clock edge of the next cycle that has `tick` high.
- R10: A value write loads `val_wdata` into the stored value and takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_mode | input | 2 | Channel mode code |
| cfg_action | input | 2 | Pin action on compare match |
| cfg_trig | input | 2 | Capture trigger mode |
| cfg_base | input | 1 | Compare key select |
| cfg_mask | input | 5 | Count of ignored MSBs |
| cfg_sel | input | 3 | Trigger line select |
| val_we | input | 1 | Write stored value |
| val_wdata | input | 32 | Stored value write data |
| tick | input | 1 | Timebase tick strobe |
| cnt | input | 32 | Main counter |
| precnt | input | 15 | Precounter |
| trig_in | input | 8 | Trigger lines |
| ccv_o | output | 32 | Stored capture/compare value |
| pin_o | output | 1 | Channel output pin |
| evt_o | output | 1 | One-cycle event flag |

## Verification
Some internal faults would appear on `evt_o` and `pin_o` one cycle after the inputs that should or should not match: a stale equality history, a wrong key packing or a wrong mask width. A stuck synchronizer or edge history shows up as a capture that is missing, arrives late or repeats, three edges after the trigger line moves. A pulse-pending flag left set appears as the pin dropping at an unexpected tick.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    CC_OFF     = 2'd0,
    CC_CAPTURE = 2'd1,
    CC_COMPARE = 2'd2,
    CC_RSVD    = 2'd3
  } cc_mode_e;

  typedef enum logic [1:0] {
    ACT_PULSE  = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cc_act_e;

  typedef enum logic [1:0] {
    TRG_RISE  = 2'd0,
    TRG_FALL  = 2'd1,
    TRG_BOTH  = 2'd2,
    TRG_LEVEL = 2'd3
  } cc_trig_e;
endpackage

// File: rtl/cc_trig_detect.sv
module cc_trig_detect import cc_pkg::*; #(
  parameter int NSEL = 8,
  localparam int SEL_W = $clog2(NSEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEL-1:0]  lines,
  input  logic [SEL_W-1:0] sel,
  input  cc_trig_e         trig_mode,
  output logic             hit
);
  logic [NSEL-1:0] meta_q, sync_q;
  logic            prev_q, line_s;

  for (genvar i = 0; i < NSEL; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= lines[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign line_s = sync_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_s;
  end

  always_comb begin
    unique case (trig_mode)
      TRG_RISE:  hit = line_s & ~prev_q;
      TRG_FALL:  hit = ~line_s & prev_q;
      TRG_BOTH:  hit = line_s ^ prev_q;
      default:   hit = line_s;
    endcase
  end
endmodule

// File: rtl/cc_match.sv
module cc_match #(
  parameter int W     = 32,
  parameter int PRE_W = 15,
  localparam int CNT_LO = W - PRE_W,
  localparam int MASK_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              base_sel,
  input  logic [MASK_W-1:0] mask_cnt,
  input  logic [W-1:0]      cnt,
  input  logic [PRE_W-1:0]  precnt,
  input  logic [W-1:0]      ref_val,
  output logic              fire
);
  logic [W-1:0] key, keep;
  logic         eq, eq_q, eq_d;

  always_comb begin
    key  = base_sel ? {cnt[CNT_LO-1:0], precnt} : cnt;
    keep = {W{1'b1}} >> mask_cnt;
    eq   = ((key ^ ref_val) & keep) == '0;
    eq_d = eq & arm;
    fire = eq_d & ~eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_d;
  end
endmodule

// File: rtl/cc_pin_action.sv
module cc_pin_action import cc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  cc_act_e act,
  input  logic    tick,
  output logic    pin
);
  logic pin_q, pin_d, pend_q, pend_d;

  always_comb begin
    pin_d  = pin_q;
    pend_d = pend_q;
    if (fire) begin
      pend_d = (act == ACT_PULSE);
      unique case (act)
        ACT_PULSE:  pin_d = 1'b1;
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        default:    pin_d = 1'b1;
      endcase
    end else if (pend_q && tick) begin
      pin_d  = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      pend_q <= pend_d;
    end
  end

  assign pin = pin_q;
endmodule

// File: rtl/cc_channel.sv
module cc_channel import cc_pkg::*; #(
  parameter int W     = 32,
  parameter int PRE_W = 15,
  parameter int NSEL  = 8,
  localparam int SEL_W  = $clog2(NSEL),
  localparam int MASK_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_action,
  input  logic [1:0]        cfg_trig,
  input  logic              cfg_base,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              val_we,
  input  logic [W-1:0]      val_wdata,
  input  logic              tick,
  input  logic [W-1:0]      cnt,
  input  logic [PRE_W-1:0]  precnt,
  input  logic [NSEL-1:0]   trig_in,
  output logic [W-1:0]      ccv_o,
  output logic              pin_o,
  output logic              evt_o
);
  cc_mode_e          mode_q, mode_d;
  cc_act_e           act_q, act_d;
  cc_trig_e          trig_q, trig_d;
  logic              base_q, base_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [W-1:0]      ccv_q, ccv_d;
  logic              evt_q, evt_d;
  logic              trig_hit, cap_fire, cmp_fire;

  cc_trig_detect #(.NSEL(NSEL)) u_trig (
    .clk(clk), .rst_n(rst_n), .lines(trig_in), .sel(sel_q),
    .trig_mode(trig_q), .hit(trig_hit)
  );

  cc_match #(.W(W), .PRE_W(PRE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .arm(mode_q == CC_COMPARE),
    .base_sel(base_q), .mask_cnt(mask_q), .cnt(cnt), .precnt(precnt),
    .ref_val(ccv_q), .fire(cmp_fire)
  );

  cc_pin_action u_pin (
    .clk(clk), .rst_n(rst_n), .fire(cmp_fire), .act(act_q),
    .tick(tick), .pin(pin_o)
  );

  assign cap_fire = trig_hit & (mode_q == CC_CAPTURE);

  always_comb begin
    mode_d = mode_q;
    act_d  = act_q;
    trig_d = trig_q;
    base_d = base_q;
    mask_d = mask_q;
    sel_d  = sel_q;
    if (cfg_we) begin
      mode_d = cc_mode_e'(cfg_mode);
      act_d  = cc_act_e'(cfg_action);
      trig_d = cc_trig_e'(cfg_trig);
      base_d = cfg_base;
      mask_d = cfg_mask;
      sel_d  = cfg_sel;
    end
    ccv_d = ccv_q;
    if (val_we)        ccv_d = val_wdata;
    else if (cap_fire) ccv_d = cnt;
    evt_d = cap_fire | cmp_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CC_OFF;
      act_q  <= ACT_PULSE;
      trig_q <= TRG_RISE;
      base_q <= 1'b0;
      mask_q <= '0;
      sel_q  <= '0;
      ccv_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      act_q  <= act_d;
      trig_q <= trig_d;
      base_q <= base_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
      ccv_q  <= ccv_d;
      evt_q  <= evt_d;
    end
  end

  assign ccv_o = ccv_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_q,
  input logic [1:0]   act_q,
  input logic         cmp_fire,
  input logic         cap_fire,
  input logic         val_we,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ccv_o,
  input logic         pin_o,
  input logic         evt_o
);
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 || mode_q == 2'd3) |=> !evt_o);

  p_capture_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !val_we) |=> (ccv_o == $past(cnt) && evt_o));

  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !cmp_fire);

  p_match_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> evt_o);

  p_set_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && act_q == 2'd3) |=> pin_o);

  p_clear_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && act_q == 2'd2) |=> !pin_o);

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && act_q == 2'd1) |=> (pin_o != $past(pin_o)));

  p_pulse_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && act_q == 2'd0) |=> pin_o);
endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_cc_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .act_q(act_q),
  .cmp_fire(cmp_fire), .cap_fire(cap_fire), .val_we(val_we), .cnt(cnt),
  .ccv_o(ccv_o), .pin_o(pin_o), .evt_o(evt_o)
);

// File: tb/cc_channel_bench.sv
`timescale 1ns/1ps
module cc_channel_bench;
  logic        clk, rst_n;
  logic        cfg_we, cfg_base, val_we, tick;
  logic [1:0]  cfg_mode, cfg_action, cfg_trig;
  logic [4:0]  cfg_mask;
  logic [2:0]  cfg_sel;
  logic [31:0] val_wdata, cnt, ccv_o;
  logic [14:0] precnt;
  logic [7:0]  trig_in;
  logic        pin_o, evt_o;
  int          total, bad;

  cc_channel u_cc_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_action(cfg_action), .cfg_trig(cfg_trig), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_sel(cfg_sel), .val_we(val_we),
    .val_wdata(val_wdata), .tick(tick), .cnt(cnt), .precnt(precnt),
    .trig_in(trig_in), .ccv_o(ccv_o), .pin_o(pin_o), .evt_o(evt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] a, logic [1:0] t,
                     logic b, logic [4:0] k, logic [2:0] s);
    cfg_we = 1'b1; cfg_mode = m; cfg_action = a; cfg_trig = t;
    cfg_base = b; cfg_mask = k; cfg_sel = s;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic wr(logic [31:0] v);
    val_we = 1'b1; val_wdata = v;
    cyc();
    val_we = 1'b0;
  endtask

  function automatic logic m_eq(logic [31:0] c, logic [14:0] p,
                                logic [31:0] v, logic b, logic [4:0] k);
    logic [31:0] key, keep;
    key  = b ? {c[16:0], p} : c;
    keep = 32'hFFFF_FFFF >> k;
    return ((key ^ v) & keep) == 32'd0;
  endfunction

  initial begin
    total = 0; bad = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cfg_action = 0; cfg_trig = 0;
    cfg_base = 0; cfg_mask = 0; cfg_sel = 0; val_we = 0; val_wdata = 0;
    tick = 0; cnt = 0; precnt = 0; trig_in = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();
    chk("R1 ccv", ccv_o, 0);
    chk("R1 pin", {31'd0, pin_o}, 0);
    chk("R1 evt", {31'd0, evt_o}, 0);

    wr(32'hDEAD_BEEF);
    chk("R10 write", ccv_o, 32'hDEAD_BEEF);

    // capture, rising, line 5
    cfg(2'd1, 2'd0, 2'd0, 1'b0, 5'd0, 3'd5);
    cnt = 32'h1234_5678;
    repeat (3) cyc();
    trig_in[5] = 1'b1; trig_in[2] = 1'b1;
    cyc(); cyc();
    chk("R3 not yet", ccv_o, 32'hDEAD_BEEF);
    cyc();
    chk("R3 capture", ccv_o, 32'h1234_5678);
    chk("R3 evt", {31'd0, evt_o}, 1);
    cyc();
    chk("R4 rise once", {31'd0, evt_o}, 0);
    trig_in[5] = 1'b0; cnt = 32'h1111;
    repeat (4) cyc();
    chk("R4 fall ignored", ccv_o, 32'h1234_5678);

    // falling
    cfg(2'd1, 2'd0, 2'd1, 1'b0, 5'd0, 3'd5);
    trig_in[5] = 1'b1;
    repeat (4) cyc();
    chk("R4 rise ignored", ccv_o, 32'h1234_5678);
    trig_in[5] = 1'b0; cnt = 32'h2222;
    repeat (3) cyc();
    chk("R4 falling", ccv_o, 32'h2222);

    // both
    cfg(2'd1, 2'd0, 2'd2, 1'b0, 5'd0, 3'd5);
    cnt = 32'h3333; trig_in[5] = 1'b1;
    repeat (3) cyc();
    chk("R4 both rise", ccv_o, 32'h3333);
    cnt = 32'h4444; trig_in[5] = 1'b0;
    repeat (3) cyc();
    chk("R4 both fall", ccv_o, 32'h4444);

    // level
    cfg(2'd1, 2'd0, 2'd3, 1'b0, 5'd0, 3'd5);
    cnt = 32'h5555;
    repeat (4) cyc();
    chk("R4 level low", ccv_o, 32'h4444);
    trig_in[5] = 1'b1;
    repeat (3) cyc();
    chk("R4 level high", ccv_o, 32'h5555);
    cnt = 32'h6666;
    cyc();
    chk("R4 level each", ccv_o, 32'h6666);
    wr(32'hAAAA);
    chk("R10 priority", ccv_o, 32'hAAAA);
    cyc();
    chk("R10 after", ccv_o, 32'h6666);

    // unselected lines
    trig_in = 8'h00;
    cfg(2'd1, 2'd0, 2'd0, 1'b0, 5'd0, 3'd5);
    repeat (4) cyc();
    cnt = 32'h7777; trig_in = 8'hDF;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R3 unselected evt", {31'd0, evt_o}, 0);
    end
    chk("R3 unselected ccv", ccv_o, 32'h6666);
    trig_in = 8'h00;

    // off modes
    for (int m = 0; m < 4; m += 3) begin
      logic p0;
      cfg(m[1:0], 2'd1, 2'd0, 1'b0, 5'd0, 3'd0);
      wr(32'h100);
      p0 = pin_o;
      cnt = 32'h100;
      repeat (3) begin
        cyc();
        chk("R2 off evt", {31'd0, evt_o}, 0);
        chk("R2 off pin", {31'd0, pin_o}, {31'd0, p0});
      end
      cnt = 32'h0;
    end

    // pulse
    cnt = 32'd0; tick = 1'b0;
    wr(32'd100);
    cfg(2'd2, 2'd0, 2'd0, 1'b0, 5'd0, 3'd0);
    cnt = 32'd99; cyc();
    chk("R7 no match", {31'd0, evt_o}, 0);
    cnt = 32'd100; cyc();
    chk("R7 first match", {31'd0, evt_o}, 1);
    chk("R9 pulse high", {31'd0, pin_o}, 1);
    cyc();
    chk("R7 held match", {31'd0, evt_o}, 0);
    chk("R9 wait tick", {31'd0, pin_o}, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R9 pulse end", {31'd0, pin_o}, 0);

    // base select
    cfg(2'd0, 2'd0, 2'd0, 1'b0, 5'd0, 3'd0);
    wr(32'h0001_8010);
    cnt = 32'h0; precnt = 15'h0;
    cfg(2'd2, 2'd3, 2'd0, 1'b1, 5'd0, 3'd0);
    cnt = 32'hFFFE_0003; precnt = 15'h0010; cyc();
    chk("R5 packed evt", {31'd0, evt_o}, 1);
    chk("R8 set", {31'd0, pin_o}, 1);
    cfg(2'd0, 2'd0, 2'd0, 1'b0, 5'd0, 3'd0);
    cfg(2'd2, 2'd2, 2'd0, 1'b0, 5'd0, 3'd0);
    cyc();
    chk("R5 full no match", {31'd0, evt_o}, 0);
    chk("R5 pin kept", {31'd0, pin_o}, 1);

    // mask 31
    cfg(2'd0, 2'd0, 2'd0, 1'b0, 5'd0, 3'd0);
    wr(32'h0000_0001);
    cnt = 32'h0;
    cfg(2'd2, 2'd1, 2'd0, 1'b0, 5'd31, 3'd0);
    cnt = 32'hFFFF_FFF1; cyc();
    chk("R6 mask31 evt", {31'd0, evt_o}, 1);
    chk("R8 toggle", {31'd0, pin_o}, 0);

    // random compare trials
    for (int t = 0; t < 60; t++) begin
      logic [31:0] v, keep;
      logic [1:0]  a;
      logic [4:0]  k;
      logic        b, meq, mpin, mpend, e, fire;
      tick = 1'b1;
      cfg(2'd0, 2'd0, 2'd0, 1'b0, 5'd0, 3'd0);
      cyc();
      tick = 1'b0;
      mpin = pin_o; mpend = 1'b0; meq = 1'b0;
      v = $urandom; a = 2'($urandom); k = 5'($urandom % 8);
      if ($urandom % 4 == 0) k = 5'($urandom);
      b = 1'($urandom);
      keep = 32'hFFFF_FFFF >> k;
      cnt = ~v; precnt = ~v[14:0];
      val_we = 1'b1; val_wdata = v;
      cfg_we = 1'b1; cfg_mode = 2'd2; cfg_action = a; cfg_trig = 2'd0;
      cfg_base = b; cfg_mask = k; cfg_sel = 3'd0;
      cyc();
      val_we = 1'b0; cfg_we = 1'b0;
      for (int c = 0; c < 25; c++) begin
        int r;
        r = int'($urandom % 4);
        if (r < 2) begin
          if (b) begin
            cnt = {$urandom, v[31:15]} ; precnt = v[14:0];
            cnt[31:17] = 15'($urandom);
          end else cnt = v;
          if (r == 1) begin
            if (b) begin
              cnt[16:0] = cnt[16:0] ^ (17'($urandom) & ~keep[31:15]);
              precnt = precnt ^ (15'($urandom) & ~keep[14:0]);
            end else cnt = cnt ^ ($urandom & ~keep);
          end
        end else begin
          cnt = $urandom; precnt = 15'($urandom);
        end
        tick = 1'($urandom);
        e = m_eq(cnt, precnt, v, b, k);
        fire = e & ~meq;
        meq = e;
        if (fire) begin
          mpend = (a == 2'd0);
          case (a)
            2'd0: mpin = 1'b1;
            2'd1: mpin = ~mpin;
            2'd2: mpin = 1'b0;
            default: mpin = 1'b1;
          endcase
        end else if (mpend && tick) begin
          mpin = 1'b0; mpend = 1'b0;
        end
        cyc();
        chk("R5 R6 R7 evt", {31'd0, evt_o}, {31'd0, fire});
        chk("R8 R9 pin", {31'd0, pin_o}, {31'd0, mpin});
      end
    end

    summary();
    $finish;
  end
endmodule